// File: doc/BRIEF.md
# Sixteen-bit Register-Pair Adder with Flag Update

This block is a purely combinational arithmetic unit for 16-bit register-pair operations. It takes a destination word, an operand word, the current flag byte and a 2-bit operation select. It returns the 16-bit result together with the updated flag byte. Three operations are supported: a plain add, an add that also takes in the carry flag, and a subtract that also takes away the carry flag as a borrow.

The plain add is the light form. It clears the subtract flag, recomputes only half-carry and carry, and leaves sign, zero and overflow exactly as they came in. The two carry forms recompute every arithmetic flag. Half-carry is taken at the boundary between bit 11 and bit 12, not at the nibble boundary a byte ALU uses. Two flag bits that have no arithmetic meaning pass straight through.

The surrounding datapath selects the register pair and writes both outputs back in the same cycle. The unit holds no state.

Top module: `wide_pair_alu`

## Requirements
- R1: With select 0 (plain add), the result is (destination + operand) mod 2^16.
- R2: With select 1 (add with carry), the result is (destination + operand + C) mod 2^16. With select 2 (subtract with borrow), the result is (destination − operand − C) mod 2^16. Here C is bit 0 of the incoming flag byte.
- R3: With select 0, the output flag bits 7, 6 and 2 equal the incoming flag bits 7, 6 and 2.
- R4: Half-carry is flag bit 4. In the add forms it is set when the low 12 bits of both words, plus the carry-in, sum to more than 0xFFF. In the subtract form it is set when the low 12 bits of the destination are less than the low 12 bits of the operand plus the borrow.
- R5: Carry is flag bit 0. In the add forms it is set when the unsigned sum, with carry-in, exceeds 0xFFFF. In the subtract form it is set when the destination is less than the operand plus the borrow.
- R6: With select 1 or 2, flag bit 2 is set exactly when the true signed result lies outside -32768..32767.
- R7: With select 1 or 2, flag bit 6 is set exactly when all 16 result bits are zero.
- R8: With select 1 or 2, flag bit 7 equals result bit 15.
- R9: Flag bit 1 (subtract marker) is set by select 2 and cleared by every other select.
- R10: Flag bits 5 and 3 leave the unit unchanged under every select.
- R11: Select 3 is reserved. It produces the same result and flags as select 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| dst_i | input | 16 | Destination register-pair value |
| src_i | input | 16 | Operand register-pair value |
| flags_i | input | 8 | Incoming flag byte; bit 0 supplies carry/borrow |
| mode_i | input | 2 | 0 add, 1 add with carry, 2 subtract with borrow, 3 reserved (as add) |
| sum_o | output | 16 | 16-bit result |
| flags_o | output | 8 | Updated flag byte |

## Verification
The same vector can produce a half-carry out of bit 11 and a carry out of bit 15. A carry-in can also ripple across both boundaries at once, as in 0xFFFF + 0x0000 with carry set. The bench provokes this by crossing the corner words 0x0000, 0x0FFF, 0x7FFF, 0x8000 and 0xFFFF under every select, with the incoming carry both clear and set. Random words and random flag bytes are added on top. Every output field is compared against an integer-arithmetic model on each clock, so the bench can tell a wrong boundary or a lost carry-in apart from an error in the preserved flags.

// File: rtl/wadd_pkg.sv
package wadd_pkg;

    // Flag byte bit positions, shared with the byte-wide ALU.
    localparam int FL_SIGN  = 7;
    localparam int FL_ZERO  = 6;
    localparam int FL_X5    = 5;
    localparam int FL_HALF  = 4;
    localparam int FL_X3    = 3;
    localparam int FL_OVF   = 2;
    localparam int FL_SUB   = 1;
    localparam int FL_CARRY = 0;

    localparam int FLAG_W   = 8;

    typedef enum logic [1:0] {
        OP_ADD  = 2'd0,
        OP_ADC  = 2'd1,
        OP_SBC  = 2'd2,
        OP_RSV  = 2'd3
    } wadd_op_e;

    // Controls derived from the select.
    typedef struct packed {
        logic invert_src;   // one's complement of the operand
        logic full_update;  // recompute sign, zero, overflow
        logic sub_flag;     // value for the subtract marker
    } wadd_ctl_t;

    function automatic wadd_ctl_t decode_op(input logic [1:0] sel);
        wadd_ctl_t c;
        c = '{invert_src: 1'b0, full_update: 1'b0, sub_flag: 1'b0};
        case (sel)
            OP_ADC: c.full_update = 1'b1;
            OP_SBC: begin
                c.invert_src  = 1'b1;
                c.full_update = 1'b1;
                c.sub_flag    = 1'b1;
            end
            default: ;
        endcase
        return c;
    endfunction

    // Signed overflow from the carries into and out of the top bit.
    function automatic logic signed_ovf(input logic c_into_msb, input logic c_out_msb);
        return c_into_msb ^ c_out_msb;
    endfunction

endpackage

// File: rtl/wadd_operand_prep.sv
module wadd_operand_prep
    import wadd_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [1:0]       mode_i,
    input  logic [WIDTH-1:0] src_i,
    input  logic             carry_flag_i,
    output logic [WIDTH-1:0] src_eff_o,
    output logic             cin_o,
    output wadd_ctl_t        ctl_o
);

    wadd_ctl_t ctl;

    always_comb begin
        ctl = decode_op(mode_i);
        // Subtract: d - s - b == d + ~s + (1 - b)
        src_eff_o = ctl.invert_src ? ~src_i : src_i;
        unique case (mode_i)
            OP_ADC:  cin_o = carry_flag_i;
            OP_SBC:  cin_o = ~carry_flag_i;
            default: cin_o = 1'b0;
        endcase
        ctl_o = ctl;
    end

endmodule

// File: rtl/wadd_seg_adder.sv
module wadd_seg_adder #(
    parameter int WIDTH = 16,
    parameter int SPLIT = 12
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic             cin_i,
    output logic [WIDTH-1:0] sum_o,
    output logic             c_split_o,  // carry out of bit SPLIT-1
    output logic             c_msb_in_o, // carry into the top bit
    output logic             c_out_o     // carry out of the top bit
);

    logic [WIDTH:0] chain;

    assign chain[0] = cin_i;

    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign sum_o[i]   = a_i[i] ^ b_i[i] ^ chain[i];
        assign chain[i+1] = (a_i[i] & b_i[i]) | (chain[i] & (a_i[i] ^ b_i[i]));
    end

    assign c_split_o  = chain[SPLIT];
    assign c_msb_in_o = chain[WIDTH-1];
    assign c_out_o    = chain[WIDTH];

endmodule

// File: rtl/wadd_flag_merge.sv
module wadd_flag_merge
    import wadd_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [WIDTH-1:0]  sum_i,
    input  logic              c_split_i,
    input  logic              c_msb_in_i,
    input  logic              c_out_i,
    input  wadd_ctl_t         ctl_i,
    output logic [FLAG_W-1:0] flags_o
);

    always_comb begin
        flags_o = flags_i;
        // In subtract form the adder carry is the inverse of the borrow.
        flags_o[FL_HALF]  = c_split_i ^ ctl_i.sub_flag;
        flags_o[FL_CARRY] = c_out_i   ^ ctl_i.sub_flag;
        flags_o[FL_SUB]   = ctl_i.sub_flag;
        if (ctl_i.full_update) begin
            flags_o[FL_SIGN] = sum_i[WIDTH-1];
            flags_o[FL_ZERO] = (sum_i == '0);
            flags_o[FL_OVF]  = signed_ovf(c_msb_in_i, c_out_i);
        end
    end

endmodule

// File: rtl/wide_pair_alu.sv
module wide_pair_alu
    import wadd_pkg::*;
#(
    parameter int WIDTH    = 16,
    parameter int HC_SPLIT = WIDTH - 4
) (
    input  logic [WIDTH-1:0]  dst_i,
    input  logic [WIDTH-1:0]  src_i,
    input  logic [FLAG_W-1:0] flags_i,
    input  logic [1:0]        mode_i,
    output logic [WIDTH-1:0]  sum_o,
    output logic [FLAG_W-1:0] flags_o
);

    logic [WIDTH-1:0] src_eff;
    logic             cin;
    wadd_ctl_t        ctl;
    logic             c_split;
    logic             c_msb_in;
    logic             c_out;

    wadd_operand_prep #(.WIDTH(WIDTH)) u_prep (
        .mode_i       (mode_i),
        .src_i        (src_i),
        .carry_flag_i (flags_i[FL_CARRY]),
        .src_eff_o    (src_eff),
        .cin_o        (cin),
        .ctl_o        (ctl)
    );

    wadd_seg_adder #(.WIDTH(WIDTH), .SPLIT(HC_SPLIT)) u_add (
        .a_i        (dst_i),
        .b_i        (src_eff),
        .cin_i      (cin),
        .sum_o      (sum_o),
        .c_split_o  (c_split),
        .c_msb_in_o (c_msb_in),
        .c_out_o    (c_out)
    );

    wadd_flag_merge #(.WIDTH(WIDTH)) u_flags (
        .flags_i    (flags_i),
        .sum_i      (sum_o),
        .c_split_i  (c_split),
        .c_msb_in_i (c_msb_in),
        .c_out_i    (c_out),
        .ctl_i      (ctl),
        .flags_o    (flags_o)
    );

endmodule

// File: rtl/wide_pair_alu_chk.sv
module wide_pair_alu_chk
    import wadd_pkg::*;
#(
    parameter int WIDTH = 16
) (
    input logic [WIDTH-1:0]  dst_i,
    input logic [WIDTH-1:0]  src_i,
    input logic [FLAG_W-1:0] flags_i,
    input logic [1:0]        mode_i,
    input logic [WIDTH-1:0]  sum_o,
    input logic [FLAG_W-1:0] flags_o
);

    logic known;
    logic [WIDTH:0] need;

    always_comb begin
        known = !$isunknown({dst_i, src_i, flags_i, mode_i});
        need  = {1'b0, src_i} + {{WIDTH{1'b0}}, flags_i[FL_CARRY]};
        if (known) begin
            // R9
            sub_marker_chk: assert (flags_o[FL_SUB] == (mode_i == OP_SBC))
                else $error("subtract marker wrong for select %0d", mode_i);
            // R10
            passthru_bits_chk: assert (flags_o[FL_X5] == flags_i[FL_X5] && flags_o[FL_X3] == flags_i[FL_X3])
                else $error("undefined flag bits altered");
            // R3
            add_keeps_chk: assert (mode_i != OP_ADD ||
                    (flags_o[FL_SIGN] == flags_i[FL_SIGN] && flags_o[FL_ZERO] == flags_i[FL_ZERO]
                     && flags_o[FL_OVF] == flags_i[FL_OVF]))
                else $error("plain add altered preserved flags");
            // R5
            add_wrap_chk: assert (mode_i != OP_ADD || flags_o[FL_CARRY] == (sum_o < dst_i))
                else $error("plain add carry disagrees with wraparound");
            // R5
            sbc_borrow_chk: assert (mode_i != OP_SBC || flags_o[FL_CARRY] == ({1'b0, dst_i} < need))
                else $error("borrow disagrees with magnitude compare");
        end
    end

endmodule

bind wide_pair_alu wide_pair_alu_chk #(.WIDTH(WIDTH)) u_chk (
    .dst_i   (dst_i),
    .src_i   (src_i),
    .flags_i (flags_i),
    .mode_i  (mode_i),
    .sum_o   (sum_o),
    .flags_o (flags_o)
);

// File: tb/test_wide_pair_alu.sv
module test_wide_pair_alu;

    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG   = 100000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [15:0] dst, src;
    logic [7:0]  fin;
    logic [1:0]  mode;
    logic [15:0] sum;
    logic [7:0]  fout;

    int compared   = 0;
    int mismatched = 0;
    bit finished   = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    wide_pair_alu i_wide_pair_alu (
        .dst_i   (dst),
        .src_i   (src),
        .flags_i (fin),
        .mode_i  (mode),
        .sum_o   (sum),
        .flags_o (fout)
    );

    task automatic cmp(input string tag, input int act, input int exp);
        compared++;
        if (act != exp) begin
            mismatched++;
            $display("FAIL %s: actual %0h expected %0h (d=%04h s=%04h f=%02h m=%0d)",
                     tag, act, exp, dst, src, fin, mode);
        end
    endtask

    // Behavioural model in plain integers.
    task automatic apply(input int d, input int s, input int f, input int m);
        int cf, b, r, sd, ss, sres, full, exp_f;
        int h, c, v;
        @(negedge clk);
        dst = 16'(d); src = 16'(s); fin = 8'(f); mode = 2'(m);
        cf = f & 1;
        sd = (d >= 32768) ? d - 65536 : d;
        ss = (s >= 32768) ? s - 65536 : s;
        if (m == 2) begin
            b    = cf;
            r    = (d - s - b) & 16'hFFFF;
            c    = (d < s + b) ? 1 : 0;
            h    = ((d & 12'hFFF) < (s & 12'hFFF) + b) ? 1 : 0;
            sres = sd - ss - b;
        end else begin
            b    = (m == 1) ? cf : 0;
            r    = (d + s + b) & 16'hFFFF;
            c    = (d + s + b > 16'hFFFF) ? 1 : 0;
            h    = ((d & 12'hFFF) + (s & 12'hFFF) + b > 12'hFFF) ? 1 : 0;
            sres = sd + ss + b;
        end
        v    = (sres < -32768 || sres > 32767) ? 1 : 0;
        full = (m == 1 || m == 2) ? 1 : 0;
        @(posedge clk);
        #1;
        cmp((m == 0) ? "R1" : (m == 3) ? "R11" : "R2", int'(sum), r);
        cmp("R4 half", int'(fout[4]), h);
        cmp("R5 carry", int'(fout[0]), c);
        cmp("R9 subtract", int'(fout[1]), (m == 2) ? 1 : 0);
        cmp("R10 bit5/3", int'({fout[5], fout[3]}), ((f >> 4) & 2) | ((f >> 3) & 1));
        if (full == 1) begin
            cmp("R6 overflow", int'(fout[2]), v);
            cmp("R7 zero", int'(fout[6]), (r == 0) ? 1 : 0);
            cmp("R8 sign", int'(fout[7]), (r >> 15) & 1);
        end else begin
            exp_f = f & 8'hC4;
            cmp("R3 keep", int'(fout & 8'hC4), exp_f);
        end
    endtask

    initial begin
        int corners[5];
        corners = '{16'h0000, 16'h0FFF, 16'h7FFF, 16'h8000, 16'hFFFF};
        dst = '0; src = '0; fin = '0; mode = '0;
        repeat (3) @(posedge clk);
        #1;
        // R1 idle state: zero inputs give zero outputs
        cmp("R1 idle", int'({sum, fout}), 0);
        rst = 1'b0;
        // Carry-in crossing both boundaries at once (R4, R5, R7)
        apply(16'hFFFF, 16'h0000, 8'h01, 1);
        apply(16'h0000, 16'h0000, 8'h01, 2);
        apply(16'h7FFF, 16'h0000, 8'h01, 1);
        apply(16'h8000, 16'h0000, 8'h01, 2);
        for (int i = 0; i < 5; i++)
            for (int j = 0; j < 5; j++)
                for (int m = 0; m < 4; m++)
                    for (int k = 0; k < 2; k++)
                        apply(corners[i], corners[j], k ? 8'hFF : 8'h28 * k, m);
        for (int n = 0; n < 2000; n++)
            apply(int'($urandom_range(0, 65535)), int'($urandom_range(0, 65535)),
                  int'($urandom_range(0, 255)), int'($urandom_range(0, 3)));
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
        $finish;
    end

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!finished) begin
            compared++;
            mismatched++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    end

endmodule